// File: doc/BRIEF.md
# Segment Table Bulk Invalidator

This block holds a small table of segment translation entries and runs the bulk segment-invalidate command against it. Each entry carries an effective segment ID, a virtual segment ID, a class bit and a valid bit. Entries are loaded through a write port. A command is a raw 32-bit instruction word. The block decodes a 3-bit invalidation hint from that word and then walks the table, one entry per clock, clearing valid bits.

A mode input picks between legacy and v3.0 behaviour. In v3.0 mode the hint decides three things: whether entry 0 is part of the walk, whether entries with a clear class bit are kept, and whether the walk is skipped. Every accepted command also raises a flush request for the translation lookaside cache. That request is a level signal that stays high until the downstream logic acknowledges it. An undefined hint raises a one-cycle warning strobe.

Top module: `slb_bulk_inval`

## Requirements
- R1: The hint is instruction bits [23:21]. No other instruction bit affects the outcome.
- R2: Each accepted command sets `flush_req_o` at the accepting edge, whatever the hint and whether or not any entry changes. It stays high until an edge where `flush_ack_i` is high and no new command is accepted.
- R3: Hints 0, 1, 2 and 6 clear the valid bit of every entry from index 1 up. Entry 0 is left untouched.
- R4: In v3.0 mode (`v3_mode_i`=1), hint 7 changes no entry. `done_o` pulses in the first cycle after the accepting edge.
- R5: In v3.0 mode, hint 4 clears every valid entry, including entry 0.
- R6: In v3.0 mode, hint 3 walks from entry 0, clears only valid entries whose class bit is 1, and keeps entries whose class bit is 0.
- R7: In v3.0 mode, hint 5 acts like hint 0. It also drives `warn_o` high for exactly the first cycle after the accepting edge.
- R8: In legacy mode (`v3_mode_i`=0), every hint acts like hint 0, class bits are ignored, and `warn_o` stays low.
- R9: Only the valid bit of a swept entry changes. Its segment IDs and class bit keep their values.
- R10: A command is accepted when `cmd_valid_i` is high and `busy_o` is low. The walk starts at index S (0 or 1) and visits one entry per cycle. `busy_o` is high from the accepting edge through a single-cycle `done_o`, which appears N−S cycles after acceptance. Commands presented while busy are ignored.
- R11: Writes presented while `busy_o` is high are dropped.
- R12: After reset all entries are invalid, and `flush_req_o`, `busy_o`, `done_o` and `warn_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Invalidate command strobe |
| cmd_instr_i | input | 32 | Raw instruction word |
| v3_mode_i | input | 1 | 1 = v3.0 semantics, 0 = legacy |
| wr_en_i | input | 1 | Entry write enable |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_valid_i | input | 1 | Valid bit to write |
| wr_esid_i | input | ESID_W | Effective segment ID to write |
| wr_vsid_i | input | VSID_W | Virtual segment ID to write |
| wr_class_i | input | 1 | Class bit to write |
| rd_idx_i | input | IDX_W | Entry index to read |
| rd_valid_o | output | 1 | Valid bit of the read entry |
| rd_esid_o | output | ESID_W | Effective segment ID of the read entry |
| rd_vsid_o | output | VSID_W | Virtual segment ID of the read entry |
| rd_class_o | output | 1 | Class bit of the read entry |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flush_req_o | output | 1 | Lookaside cache flush request (level) |
| flush_ack_i | input | 1 | Flush acknowledge |
| warn_o | output | 1 | Undefined-hint warning pulse |

## Verification
All outputs are sampled on the falling edge.

- **Acceptance cycle.** `busy_o` and `flush_req_o` are due in the first falling-edge sample after the accepting edge, and `warn_o` is due in that same sample only. The bench checks all three there and checks `warn_o` low one cycle later.
- **Completion.** The bench counts falling edges until `done_o` appears and compares the count with N−S, or with 0 for the skip-all hint. It then expects `busy_o` low one edge later.
- **Table contents.** The read port is combinational, so the whole table is read back after completion with no wait. Each entry is compared against the prediction from the hint, mode, start index and class bit.
- **Flush acknowledge.** Clearing of the flush request is checked one edge after the acknowledge is driven.

// File: rtl/slbinv_pkg.sv
package slbinv_pkg;
  localparam int HINT_LSB = 21;
  localparam int HINT_W   = 3;

  typedef struct packed {
    logic start_zero;
    logic skip_all;
    logic class_only;
    logic undef;
  } scope_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SWEEP, ST_FIN} sweep_st_e;
endpackage

// File: rtl/slb_hint_decode.sv
module slb_hint_decode
  import slbinv_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        v3_mode_i,
  output scope_t      scope_o
);
  logic [HINT_W-1:0] hint;
  logic              unused_instr;

  assign hint         = instr_i[HINT_LSB +: HINT_W];
  assign unused_instr = ^instr_i;

  always_comb begin
    scope_o = '0;
    if (v3_mode_i) begin
      unique case (hint)
        3'd3: begin scope_o.start_zero = 1'b1; scope_o.class_only = 1'b1; end
        3'd4: scope_o.start_zero = 1'b1;
        3'd5: scope_o.undef      = 1'b1;
        3'd7: scope_o.skip_all   = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/slb_entry_array.sv
module slb_entry_array #(
  parameter int NUM_ENTRIES = 32,
  parameter int ESID_W      = 36,
  parameter int VSID_W      = 52,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [ESID_W-1:0] wr_esid_i,
  input  logic [VSID_W-1:0] wr_vsid_i,
  input  logic              wr_class_i,
  input  logic              clr_en_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic [IDX_W-1:0]  scan_idx_i,
  output logic              scan_valid_o,
  output logic              scan_class_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [ESID_W-1:0] rd_esid_o,
  output logic [VSID_W-1:0] rd_vsid_o,
  output logic              rd_class_o
);
  logic [NUM_ENTRIES-1:0] valid_q;
  logic [NUM_ENTRIES-1:0] class_q;
  logic [ESID_W-1:0]      esid_q [NUM_ENTRIES];
  logic [VSID_W-1:0]      vsid_q [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic wr_hit, clr_hit;
    assign wr_hit  = wr_en_i  && (wr_idx_i  == IDX_W'(g));
    assign clr_hit = clr_en_i && (clr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      valid_q[g] <= 1'b0;
      else if (wr_hit)  valid_q[g] <= wr_valid_i;
      else if (clr_hit) valid_q[g] <= 1'b0;
    end

    // payload is not reset; only the valid bit defines entry state
    always_ff @(posedge clk_i) begin
      if (wr_hit) begin
        esid_q[g]  <= wr_esid_i;
        vsid_q[g]  <= wr_vsid_i;
        class_q[g] <= wr_class_i;
      end
    end
  end

  assign scan_valid_o = valid_q[scan_idx_i];
  assign scan_class_o = class_q[scan_idx_i];
  assign rd_valid_o   = valid_q[rd_idx_i];
  assign rd_esid_o    = esid_q[rd_idx_i];
  assign rd_vsid_o    = vsid_q[rd_idx_i];
  assign rd_class_o   = class_q[rd_idx_i];

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !wr_en_i) |=> !valid_q[$past(clr_idx_i)]); // R9
endmodule

// File: rtl/slb_sweep_ctrl.sv
module slb_sweep_ctrl
  import slbinv_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  scope_t           scope_i,
  input  logic             ent_valid_i,
  input  logic             ent_class_i,
  input  logic             flush_ack_i,
  output logic [IDX_W-1:0] scan_idx_o,
  output logic             clr_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             flush_req_o,
  output logic             warn_o
);
  sweep_st_e        st_q;
  scope_t           scope_q;
  logic [IDX_W-1:0] idx_q;
  logic             flush_q, warn_q, accept;

  assign accept = (st_q == ST_IDLE) && cmd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      scope_q <= '0;
      idx_q   <= '0;
      flush_q <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      warn_q <= 1'b0;
      if (flush_ack_i) flush_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          scope_q <= scope_i;
          flush_q <= 1'b1;          // set wins over ack
          warn_q  <= scope_i.undef;
          idx_q   <= scope_i.start_zero ? '0 : IDX_W'(1);
          st_q    <= scope_i.skip_all ? ST_FIN : ST_SWEEP;
        end
        ST_SWEEP: begin
          if (idx_q == LAST_IDX) st_q <= ST_FIN;
          else                   idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_idx_o  = idx_q;
  assign clr_en_o    = (st_q == ST_SWEEP) && ent_valid_i &&
                       (!scope_q.class_only || ent_class_i);
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign flush_req_o = flush_q;
  assign warn_o      = warn_q;

  AST_FLUSH_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> flush_req_o); // R2
  AST_WARN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |=> !warn_o); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R10
  AST_CLASS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_o && scope_q.class_only) |-> ent_class_i); // R6
endmodule

// File: rtl/slb_bulk_inval.sv
module slb_bulk_inval
  import slbinv_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int ESID_W      = 36,
  parameter int VSID_W      = 52,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_instr_i,
  input  logic              v3_mode_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [ESID_W-1:0] wr_esid_i,
  input  logic [VSID_W-1:0] wr_vsid_i,
  input  logic              wr_class_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [ESID_W-1:0] rd_esid_o,
  output logic [VSID_W-1:0] rd_vsid_o,
  output logic              rd_class_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              flush_req_o,
  input  logic              flush_ack_i,
  output logic              warn_o
);
  scope_t           scope;
  logic [IDX_W-1:0] scan_idx;
  logic             scan_valid, scan_class, clr_en, wr_fire;

  assign wr_fire = wr_en_i && !busy_o;

  slb_hint_decode i_decode (
    .instr_i   (cmd_instr_i),
    .v3_mode_i (v3_mode_i),
    .scope_o   (scope)
  );

  slb_sweep_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .scope_i     (scope),
    .ent_valid_i (scan_valid),
    .ent_class_i (scan_class),
    .flush_ack_i (flush_ack_i),
    .scan_idx_o  (scan_idx),
    .clr_en_o    (clr_en),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .flush_req_o (flush_req_o),
    .warn_o      (warn_o)
  );

  slb_entry_array #(
    .NUM_ENTRIES(NUM_ENTRIES), .ESID_W(ESID_W), .VSID_W(VSID_W)
  ) i_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_fire),
    .wr_idx_i     (wr_idx_i),
    .wr_valid_i   (wr_valid_i),
    .wr_esid_i    (wr_esid_i),
    .wr_vsid_i    (wr_vsid_i),
    .wr_class_i   (wr_class_i),
    .clr_en_i     (clr_en),
    .clr_idx_i    (scan_idx),
    .scan_idx_i   (scan_idx),
    .scan_valid_o (scan_valid),
    .scan_class_o (scan_class),
    .rd_idx_i     (rd_idx_i),
    .rd_valid_o   (rd_valid_o),
    .rd_esid_o    (rd_esid_o),
    .rd_vsid_o    (rd_vsid_o),
    .rd_class_o   (rd_class_o)
  );

  AST_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_i && !clr_en && rd_idx_i == wr_idx_i) |=>
      $stable(rd_esid_o) || $changed(rd_idx_i)); // R11
endmodule

// File: tb/test_slb_bulk_inval.sv
module test_slb_bulk_inval;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = $clog2(N);
  localparam int EW = 36;
  localparam int VW = 52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, v3_mode = 0, wr_en = 0, wr_valid = 0, wr_class = 0, flush_ack = 0;
  logic [31:0] instr = '0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [EW-1:0] wr_esid = '0;
  logic [VW-1:0] wr_vsid = '0;
  logic rd_valid, rd_class, busy, done, flush_req, warn;
  logic [EW-1:0] rd_esid;
  logic [VW-1:0] rd_vsid;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slb_bulk_inval #(.NUM_ENTRIES(N), .ESID_W(EW), .VSID_W(VW)) i_slb_bulk_inval (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_instr_i(instr),
    .v3_mode_i(v3_mode), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid),
    .wr_esid_i(wr_esid), .wr_vsid_i(wr_vsid), .wr_class_i(wr_class),
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_esid_o(rd_esid), .rd_vsid_o(rd_vsid),
    .rd_class_o(rd_class), .busy_o(busy), .done_o(done), .flush_req_o(flush_req),
    .flush_ack_i(flush_ack), .warn_o(warn)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pv(int i, int k); return ((i + k) % 3) != 0; endfunction
  function automatic logic pc(int i, int k); return ((i + k) % 2) != 0; endfunction
  function automatic longint pe(int i, int k); return i * 7 + k * 100 + 3; endfunction
  function automatic longint pw(int i, int k); return i * 13 + k * 5 + 1; endfunction

  task automatic run_case(input logic v3, input int h, input int k, input bit disturb);
    int c;
    bit skip, cls_only, exp_warn;
    int start;
    string tag;
    logic [31:0] base;
    skip     = v3 && h == 7;
    cls_only = v3 && h == 3;
    start    = (v3 && (h == 3 || h == 4)) ? 0 : 1;
    exp_warn = v3 && h == 5;
    tag = !v3 ? "R8" : h == 7 ? "R4" : h == 3 ? "R6" : h == 4 ? "R5" : h == 5 ? "R7" : "R3";
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      wr_en = 1; wr_idx = IW'(i); wr_valid = pv(i, k); wr_class = pc(i, k);
      wr_esid = EW'(pe(i, k)); wr_vsid = VW'(pw(i, k));
    end
    @(negedge clk);
    wr_en = 0;
    base = (k % 2) ? 32'hFF1F_FFFF : 32'h0000_0000;
    instr = (base & ~(32'h7 << 21)) | (32'(h) << 21);
    v3_mode = v3; cmd_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk("R10 busy after accept", busy, 1);
    chk("R2 flush set", flush_req, 1);
    chk({tag, " R7 warn first cycle"}, warn, exp_warn);
    if (disturb) begin
      wr_en = 1; wr_idx = 2; wr_valid = 1; wr_esid = 999; wr_class = 1;
      cmd_valid = 1; v3_mode = 1; instr = 32'h7 << 21;
    end
    c = 0;
    while (!done && c < 4 * N) begin
      @(posedge clk);
      @(negedge clk);
      c++;
      wr_en = 0; cmd_valid = 0;
      if (c == 1) chk("R7 warn one cycle", warn, 0);
    end
    chk({tag, " R10 done cycle"}, c, skip ? 0 : N - start);
    chk("R10 busy at done", busy, 1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 idle after done", busy, 0);
    chk("R10 done single", done, 0);
    for (int i = 0; i < N; i++) begin
      bit exp_v;
      exp_v = pv(i, k) && !(!skip && i >= start && (!cls_only || pc(i, k)));
      rd_idx = IW'(i);
      #1;
      chk({"R1 ", tag, " valid"}, rd_valid, exp_v);
      chk(disturb ? "R11 esid kept" : "R9 esid kept", rd_esid, pe(i, k));
      chk("R9 vsid kept", rd_vsid, pw(i, k));
      chk("R9 class kept", rd_class, pc(i, k));
    end
    chk("R2 flush held", flush_req, 1);
    @(negedge clk);
    flush_ack = 1;
    @(posedge clk);
    @(negedge clk);
    flush_ack = 0;
    chk("R2 flush cleared", flush_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R12 busy", busy, 0);
    chk("R12 flush", flush_req, 0);
    chk("R12 done", done, 0);
    chk("R12 warn", warn, 0);
    for (int i = 0; i < N; i++) begin
      rd_idx = IW'(i);
      #1;
      chk("R12 invalid", rd_valid, 0);
    end
    rst_n = 1;
    for (int m = 0; m < 2; m++)
      for (int h = 0; h < 8; h++)
        for (int k = 0; k < 2; k++)
          run_case(m[0], h, k, 1'b0);
    run_case(1'b0, 0, 1, 1'b1);
    run_case(1'b1, 3, 0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule